// File: doc/BRIEF.md
# Global-History Indexed Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a table of 2-bit saturating counters and a global history register that records the resolved outcome of every branch, whatever its address. A table index is formed from the low bits of a branch PC and the history. One parameter picks how the two are combined. They can be joined side by side, so each PC slot has its own set of history-selected counters. They can instead be folded together with XOR, so the table is shared.

The front end presents a PC on the lookup port and receives a taken / not-taken guess in the same cycle, with no register on the path. When a branch resolves, the back end presents its PC and real outcome on the update port. The counter selected with the current history is trained, and the outcome is then shifted into the history. Setting the history width to zero gives a table indexed only by PC. Setting the PC width to zero gives a table indexed only by history.

Top module: `gpred_top`

## Requirements
- R1: With SHARED = 0, the index of a PC under history h is (pc mod 2^PC_BITS) + h * 2^PC_BITS, where h is the HIST_BITS-bit history. The table holds 2^(PC_BITS+HIST_BITS) counters.
- R2: With SHARED = 1, the index is (pc mod 2^PC_BITS) XOR h, where h is a PC_BITS-bit history. The table holds 2^PC_BITS counters.
- R3: With SHARED = 0 and HIST_BITS = 0, the prediction depends only on the low PC_BITS bits of the PC and on the past outcomes at that same slot.
- R4: With SHARED = 0 and PC_BITS = 0, the prediction depends only on the global history and is the same for every PC.
- R5: Each counter encodes 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. The prediction is taken (1) exactly when bit 1 of the selected counter is 1.
- R6: After reset every counter holds 01 and the history holds all zeros, so every lookup predicts not taken.
- R7: An update adds one to the counter on a taken outcome and subtracts one on a not-taken outcome. It saturates at 11 and at 00.
- R8: An update trains the entry indexed with the history as it was before that update. In the same clock edge, the history shifts left with 1 (taken) or 0 (not taken) entering at bit 0. The history changes only on an update.
- R9: The history is shared by all branches, so an update at one PC changes the index used for every other PC.
- R10: When a lookup and an update select the same entry in one cycle, the lookup returns the counter value from before that update.
- R11: The prediction is a combinational function of the lookup PC and the current state, valid in the same cycle the PC is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lkp_pc | input | PC_W | PC of the branch being predicted |
| lkp_taken | output | 1 | Prediction: 1 taken, 0 not taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The bench builds four copies that share the same stimulus:
- side-by-side index with PC_BITS = 4 and HIST_BITS = 2;
- XOR index with PC_BITS = 4;
- side-by-side with HIST_BITS = 0, a pure PC-indexed table;
- side-by-side with PC_BITS = 0 and HIST_BITS = 3, a pure history-indexed table.

Run side by side on identical traffic, the four copies show each index mode differing from the others. The small widths let the test reach saturation at both ends, history wrap-around and aliasing between PCs within a few hundred cycles. Same-entry lookup and update collisions are also reached often.

// File: rtl/gpred_pkg.sv
package gpred_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // Saturating step of a 2-bit direction counter.
  function automatic ctr_t ctr_train(ctr_t c, logic taken);
    if (taken) return (c == CTR_ST) ? c : ctr_t'(c + 2'd1);
    else       return (c == CTR_SNT) ? c : ctr_t'(c - 2'd1);
  endfunction

  function automatic logic ctr_says_taken(ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/gpred_index.sv
module gpred_index #(
  parameter int PC_W    = 32,
  parameter int PC_BITS = 4,
  parameter int HWS     = 2,
  parameter int IDX_W   = 6,
  parameter bit SHARED  = 1'b0
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [HWS-1:0]   hist,
  output logic [IDX_W-1:0] idx
);

  for (genvar i = 0; i < IDX_W; i++) begin : g_bit
    if (SHARED) begin : g_xor
      assign idx[i] = pc[i] ^ hist[i];
    end else if (i < PC_BITS) begin : g_pc
      assign idx[i] = pc[i];
    end else begin : g_hist
      assign idx[i] = hist[i-PC_BITS];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{pc, hist};

endmodule

// File: rtl/gpred_history.sv
module gpred_history #(
  parameter int HW  = 2,
  parameter int HWS = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd_valid,
  input  logic           upd_taken,
  output logic [HWS-1:0] hist_q
);

  if (HW > 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            hist_q <= '0;
      else if (upd_valid) hist_q <= (hist_q << 1) | HWS'(upd_taken);
    end
  end else begin : g_none
    assign hist_q = '0;
    logic unused_in;
    assign unused_in = ^{clk, rst, upd_valid, upd_taken};
  end

endmodule

// File: rtl/gpred_table.sv
module gpred_table
  import gpred_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int ENTRIES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output ctr_t             wr_old,
  output ctr_t             wr_new
);

  ctr_t ctr_q [ENTRIES];

  assign rd_ctr = ctr_q[rd_idx];
  assign wr_old = ctr_q[wr_idx];
  assign wr_new = ctr_train(wr_old, wr_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) ctr_q[e] <= CTR_WNT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_new;
    end
  end

endmodule

// File: rtl/gpred_top.sv
module gpred_top
  import gpred_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_BITS   = 4,
  parameter int HIST_BITS = 2,
  parameter bit SHARED    = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lkp_pc,
  output logic            lkp_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam int HW      = SHARED ? PC_BITS : HIST_BITS;
  localparam int HWS     = (HW > 0) ? HW : 1;
  localparam int IDX_W   = SHARED ? PC_BITS : PC_BITS + HIST_BITS;
  localparam int ENTRIES = 1 << IDX_W;

  logic [HWS-1:0]   hist_q;
  logic [IDX_W-1:0] lkp_idx;
  logic [IDX_W-1:0] upd_idx;
  ctr_t             lkp_ctr;
  ctr_t             upd_ctr_old;
  ctr_t             upd_ctr_new;

  gpred_index #(
    .PC_W(PC_W), .PC_BITS(PC_BITS), .HWS(HWS), .IDX_W(IDX_W), .SHARED(SHARED)
  ) u_lkp_index (
    .pc(lkp_pc), .hist(hist_q), .idx(lkp_idx)
  );

  gpred_index #(
    .PC_W(PC_W), .PC_BITS(PC_BITS), .HWS(HWS), .IDX_W(IDX_W), .SHARED(SHARED)
  ) u_upd_index (
    .pc(upd_pc), .hist(hist_q), .idx(upd_idx)
  );

  gpred_history #(
    .HW(HW), .HWS(HWS)
  ) u_history (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_taken(upd_taken),
    .hist_q(hist_q)
  );

  gpred_table #(
    .IDX_W(IDX_W), .ENTRIES(ENTRIES)
  ) u_table (
    .clk(clk), .rst(rst),
    .rd_idx(lkp_idx), .rd_ctr(lkp_ctr),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken),
    .wr_old(upd_ctr_old), .wr_new(upd_ctr_new)
  );

  assign lkp_taken = ctr_says_taken(lkp_ctr);

endmodule

// File: rtl/gpred_chk.sv
module gpred_chk #(
  parameter int HW    = 2,
  parameter int HWS   = 2,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             upd_valid,
  input logic             upd_taken,
  input logic             lkp_taken,
  input logic [HWS-1:0]   hist_q,
  input logic [IDX_W-1:0] lkp_idx,
  input logic [IDX_W-1:0] upd_idx,
  input logic [1:0]       upd_ctr_old,
  input logic [1:0]       upd_ctr_new
);

  localparam logic [HWS-1:0] HMASK = (HW > 0) ? {HWS{1'b1}} : {HWS{1'b0}};

  // R6
  hist_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> hist_q == '0);

  // R8
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> hist_q == ((($past(hist_q) << 1) | HWS'($past(upd_taken))) & HMASK));

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(hist_q));

  // R7
  sat_top_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid && upd_taken && upd_ctr_old == 2'b11 |-> upd_ctr_new == 2'b11);

  // R7
  sat_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid && !upd_taken && upd_ctr_old == 2'b00 |-> upd_ctr_new == 2'b00);

  // R10
  same_entry_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid && lkp_idx == upd_idx |-> lkp_taken == upd_ctr_old[1]);

endmodule

bind gpred_top gpred_chk #(.HW(HW), .HWS(HWS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .lkp_taken(lkp_taken), .hist_q(hist_q), .lkp_idx(lkp_idx), .upd_idx(upd_idx),
  .upd_ctr_old(upd_ctr_old), .upd_ctr_new(upd_ctr_new)
);

// File: tb/gpred_top_tb.sv
`timescale 1ns/1ps
module gpred_top_tb;

  localparam int NDUT = 4;
  localparam int NP[NDUT] = '{4, 4, 3, 0};
  localparam int MP[NDUT] = '{2, 0, 0, 3};
  localparam bit SP[NDUT] = '{1'b0, 1'b1, 1'b0, 1'b0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lkp_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pred [NDUT];

  always #4 clk = ~clk;

  for (genvar g = 0; g < NDUT; g++) begin : g_dut
    gpred_top #(
      .PC_W(32), .PC_BITS(NP[g]), .HIST_BITS(MP[g]), .SHARED(SP[g])
    ) u_dut (
      .clk(clk), .rst(rst), .lkp_pc(lkp_pc), .lkp_taken(pred[g]),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );
  end

  typedef struct {
    int    d;
    bit    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // Reference model written from the requirements.
  int mt [NDUT][64];
  int mh [NDUT];
  string dtag [NDUT] = '{"R1", "R2", "R3", "R4"};

  function automatic int msk(int w);
    return (1 << w) - 1;
  endfunction

  function automatic int hwidth(int d);
    return SP[d] ? NP[d] : MP[d];
  endfunction

  function automatic int midx(int d, int pc, int h);
    if (SP[d]) return (pc & msk(NP[d])) ^ (h & msk(NP[d]));
    return (pc & msk(NP[d])) + (h & msk(MP[d])) * (1 << NP[d]);
  endfunction

  task automatic model_reset();
    for (int d = 0; d < NDUT; d++) begin
      mh[d] = 0;
      for (int e = 0; e < 64; e++) mt[d][e] = 1;
    end
  endtask

  // Driver: one cycle of stimulus, expectations pushed before the model trains.
  task automatic step(int lpc, bit uv, int upc, bit ut, string tag);
    @(negedge clk);
    lkp_pc    = 32'(lpc);
    upd_valid = uv;
    upd_pc    = 32'(upc);
    upd_taken = ut;
    for (int d = 0; d < NDUT; d++) begin
      item_t it;
      it.d   = d;
      it.exp = (mt[d][midx(d, lpc, mh[d])] >= 2);
      it.tag = (tag == "") ? dtag[d] : tag;
      q.push_back(it);
    end
    if (uv) begin
      for (int d = 0; d < NDUT; d++) begin
        int ix;
        ix = midx(d, upc, mh[d]);
        if (ut && mt[d][ix] < 3) mt[d][ix]++;
        if (!ut && mt[d][ix] > 0) mt[d][ix]--;
        mh[d] = ((mh[d] << 1) | int'(ut)) & msk(hwidth(d));
      end
    end
  endtask

  // Monitor: compares in the same cycle the PC is presented (R11).
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_run++;
        if (pred[it.d] !== it.exp) begin
          n_fail++;
          $display("FAIL %s dut%0d: prediction %b, expected %b", it.tag, it.d, pred[it.d], it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned lf;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R6: all entries start weak not-taken
    for (int p = 0; p < 16; p++) step(p, 1'b0, 0, 1'b0, "R6");

    // R5 and R7: drive one PC up into saturation and back down
    for (int k = 0; k < 6; k++) step(2, 1'b1, 2, 1'b1, "R5");
    for (int k = 0; k < 6; k++) step(2, 1'b1, 2, 1'b0, "R7");
    for (int k = 0; k < 2; k++) step(2, 1'b1, 2, 1'b1, "R7");

    // R10/R11: lookup and update at the same PC in the same cycle
    for (int k = 0; k < 8; k++) step(5, 1'b1, 5, (k % 3) != 0, "R10");

    // R9: updates at other PCs move the history seen by PC 9
    for (int k = 0; k < 12; k++) step(9, 1'b1, k, k[0], "R9");

    // R8: idle cycles leave history and table unchanged
    for (int k = 0; k < 6; k++) step(k, 1'b0, 0, 1'b0, "R8");

    // Mixed traffic judged per index mode (R1, R2, R3, R4)
    lf = 32'h1234_5677;
    for (int k = 0; k < 400; k++) begin
      int up;
      lf = lf * 1103515245 + 12345;
      up = int'((lf >> 16) & 15);
      step(int'((lf >> 20) & 15), (lf >> 8) % 4 != 0, up,
           (up < 8) ? ((lf >> 12) % 5 != 0) : ((lf >> 12) % 5 == 0), "");
    end

    // R6: reset again mid-run restores the power-up state
    @(negedge clk);
    rst = 1'b1;
    upd_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    for (int p = 0; p < 8; p++) step(p, 1'b0, 0, 1'b0, "R6");

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule